// File: doc/BRIEF.md
# Drafting-Aware Pipeline Energy Accumulator

This block estimates the dynamic energy a two-thread in-order pipeline spends as it issues instructions. Each cycle in which the issue stage sends an instruction, the block adds a fixed-point energy charge to a running total. The charge is the sum of six per-stage costs: fetch, thread select, decode, execute, memory and writeback. Some of those costs are left out when the instruction follows an identical or near-identical instruction from the other thread. Each instruction is modelled as taking one issue cycle, so one charge is added per issue strobe.

The issue stage gives four inputs: a valid strobe, a flag saying the two threads are running in lockstep, a flag saying this instruction rides behind the previous one, and a two-bit duplicate class. A following instruction that matches the previous one exactly and issues in lockstep needs no fetch, thread-select or decode work. A following instruction that shares only the opcode still needs its own fetch and thread select, but reuses the decode. Every other issue pays the full cost. Three event counters record how many issues fell into each charging category. A synchronous clear zeroes the total and the counters.

Costs are unsigned values in units of 2^-24 nJ. The total saturates at the largest value its width can hold.

Top module: `edraft_energy_acc`

## Requirements
- R1: After the asynchronous reset, the energy total and all three event counters read zero.
- R2: An issue that is neither a lockstep drafted full duplicate nor a drafted partial duplicate adds 28626124 units to the total and increments the ordinary counter. This covers dup_class 2'b00 (none) and 2'b11 (reserved), undrafted issues of any class, and a drafted full duplicate while not in lockstep.
- R3: An issue with drafted=1, sync=1 and dup_class=2'b10 (full duplicate) adds 17519188 units and increments the full-duplicate counter. This is the sum of the execute, memory and writeback costs.
- R4: An issue with drafted=1 and dup_class=2'b01 (partial duplicate) adds 28282611 units, whatever the value of sync, and increments the partial-duplicate counter. This is the full cost minus the decode cost of 343513.
- R5: The execute, memory and writeback costs, the register file read among them, are part of every charge. A cycle with issue_vld=0 changes neither the total nor any counter.
- R6: When an addition would exceed 2^ACC_W-1, the total becomes 2^ACC_W-1 and stays there while further issues arrive.
- R7: Each issue increments exactly one of the three counters by one.
- R8: With clr=1 at a clock edge, the total and all counters become zero at that edge, even if an issue arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the total and the counters |
| issue_vld | input | 1 | An instruction issues this cycle |
| sync | input | 1 | The threads are in lockstep |
| drafted | input | 1 | This instruction follows a matching one |
| dup_class | input | 2 | 00 none, 01 partial, 10 full, 11 reserved |
| energy_o | output | ACC_W | Accumulated energy in units of 2^-24 nJ |
| cnt_full_o | output | CNT_W | Lockstep full-duplicate issues |
| cnt_part_o | output | CNT_W | Partial-duplicate issues |
| cnt_ord_o | output | CNT_W | Ordinary issues |

## Verification
Every output comes from a register that is loaded at the edge where the issue or clear is sampled, so each result is due one clock edge after its stimulus. The bench applies a stimulus at a falling edge and compares the total and the counters at the next falling edge. By then the single rising edge in between has loaded them, and the inputs for the next step go on at that same point. The bench keeps its own running total with saturation, built from the stated per-category charges. After every step it compares all four outputs against that total and the expected counts.

// File: rtl/edraft_pkg.sv
package edraft_pkg;

  localparam int unsigned COST_W   = 26;
  localparam int unsigned N_STAGE  = 6;
  localparam int unsigned N_CAT    = 3;

  typedef enum logic [1:0] {
    DUP_NONE = 2'b00,
    DUP_PART = 2'b01,
    DUP_FULL = 2'b10,
    DUP_RSVD = 2'b11
  } dup_e;

  // category index into the event vector
  localparam int unsigned CAT_ORD  = 0;
  localparam int unsigned CAT_PART = 1;
  localparam int unsigned CAT_FULL = 2;

  // stage costs in 2^-24 nJ: fetch, thread select, decode, execute, memory, writeback
  localparam logic [COST_W-1:0] STAGE_COST [N_STAGE] = '{
    26'd10162274, 26'd601149, 26'd343513, 26'd7843558, 26'd5438964, 26'd4236666
  };

  // per category, stages left out of the charge (bit i = stage i)
  localparam logic [N_STAGE-1:0] SKIP_MASK [N_CAT] = '{
    6'b000000,   // ordinary
    6'b000100,   // partial duplicate: decode
    6'b000111    // full duplicate in lockstep: fetch, select, decode
  };

endpackage

// File: rtl/edraft_classify.sv
module edraft_classify
  import edraft_pkg::*;
(
  input  logic              issue_vld,
  input  logic              sync,
  input  logic              drafted,
  input  logic [1:0]        dup_class,
  output logic [N_CAT-1:0]  cat_inc,
  output logic [COST_W-1:0] cost
);

  logic [N_CAT-1:0] cat_sel;
  logic [N_STAGE-1:0] skip;

  always_comb begin
    cat_sel = '0;
    if (drafted && sync && dup_class == DUP_FULL) begin
      cat_sel[CAT_FULL] = 1'b1;
    end else if (drafted && dup_class == DUP_PART) begin
      cat_sel[CAT_PART] = 1'b1;
    end else begin
      cat_sel[CAT_ORD] = 1'b1;
    end
  end

  always_comb begin
    skip = '0;
    for (int c = 0; c < N_CAT; c++) begin
      if (cat_sel[c]) skip = skip | SKIP_MASK[c];
    end
  end

  always_comb begin
    cost = '0;
    if (issue_vld) begin
      for (int s = 0; s < N_STAGE; s++) begin
        if (!skip[s]) cost = cost + STAGE_COST[s];
      end
    end
  end

  assign cat_inc = issue_vld ? cat_sel : '0;

endmodule

// File: rtl/edraft_sat_acc.sv
module edraft_sat_acc #(
  parameter int unsigned ACC_W  = 48,
  parameter int unsigned COST_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add_en,
  input  logic [COST_W-1:0] add_val,
  output logic [ACC_W-1:0]  acc
);

  localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};

  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] acc_nxt;
  logic             acc_en;

  assign sum    = {1'b0, acc} + {{(ACC_W+1-COST_W){1'b0}}, add_val};
  assign acc_en = clr | add_en;

  always_comb begin
    if (clr)          acc_nxt = '0;
    else if (sum[ACC_W]) acc_nxt = ACC_MAX;
    else              acc_nxt = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (acc_en) acc <= acc_nxt;
  end

  a_r6_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_MAX && !clr) |=> acc == ACC_MAX);

  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> acc >= $past(acc));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> acc == '0);

endmodule

// File: rtl/edraft_evt_cnt.sv
module edraft_evt_cnt #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned N     = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic [N-1:0]            inc,
  output logic [N-1:0][CNT_W-1:0] cnt
);

  for (genvar g = 0; g < N; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt_nxt;
    logic             cnt_en;

    assign cnt_en  = clr | inc[g];
    assign cnt_nxt = clr ? '0 : cnt[g] + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt[g] <= '0;
      else if (cnt_en) cnt[g] <= cnt_nxt;
    end

    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !inc[g]) |=> $stable(cnt[g]));
  end

endmodule

// File: rtl/edraft_energy_acc.sv
module edraft_energy_acc
  import edraft_pkg::*;
#(
  parameter int unsigned ACC_W = 48,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             issue_vld,
  input  logic             sync,
  input  logic             drafted,
  input  logic [1:0]       dup_class,
  output logic [ACC_W-1:0] energy_o,
  output logic [CNT_W-1:0] cnt_full_o,
  output logic [CNT_W-1:0] cnt_part_o,
  output logic [CNT_W-1:0] cnt_ord_o
);

  logic [N_CAT-1:0]            cat_inc;
  logic [COST_W-1:0]           cost;
  logic [N_CAT-1:0][CNT_W-1:0] cnt;

  edraft_classify u_cls (
    .issue_vld (issue_vld),
    .sync      (sync),
    .drafted   (drafted),
    .dup_class (dup_class),
    .cat_inc   (cat_inc),
    .cost      (cost)
  );

  edraft_sat_acc #(.ACC_W(ACC_W), .COST_W(COST_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .add_en  (issue_vld),
    .add_val (cost),
    .acc     (energy_o)
  );

  edraft_evt_cnt #(.CNT_W(CNT_W), .N(N_CAT)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .inc   (cat_inc),
    .cnt   (cnt)
  );

  assign cnt_ord_o  = cnt[CAT_ORD];
  assign cnt_part_o = cnt[CAT_PART];
  assign cnt_full_o = cnt[CAT_FULL];

  a_r7_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> $countones(cat_inc) == 1);

  a_r5_no_issue_no_charge: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_vld && !clr) |=> $stable(energy_o));

  a_r3_full_cheapest: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && cat_inc[CAT_FULL]) |-> cost == STAGE_COST[3] + STAGE_COST[4] + STAGE_COST[5]);

endmodule

// File: tb/edraft_energy_acc_tb.sv
module edraft_energy_acc_tb;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned ACC_W = 30;
  localparam int unsigned CNT_W = 32;
  localparam longint unsigned MAXV = (64'd1 << ACC_W) - 1;

  localparam longint unsigned C_ORD  = 28626124;
  localparam longint unsigned C_PART = 28282611;
  localparam longint unsigned C_FULL = 17519188;

  // {issue, sync, drafted, class[1:0], kind[1:0]}; kind 0 none,1 ord,2 part,3 full
  localparam int NV = 12;
  localparam logic [6:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,2'b00,2'd1},
    {1'b1,1'b1,1'b1,2'b10,2'd3},
    {1'b1,1'b0,1'b1,2'b10,2'd1},
    {1'b1,1'b1,1'b0,2'b10,2'd1},
    {1'b1,1'b0,1'b1,2'b01,2'd2},
    {1'b1,1'b1,1'b1,2'b01,2'd2},
    {1'b1,1'b1,1'b0,2'b01,2'd1},
    {1'b1,1'b1,1'b1,2'b11,2'd1},
    {1'b0,1'b1,1'b1,2'b10,2'd0},
    {1'b1,1'b1,1'b1,2'b00,2'd1},
    {1'b1,1'b1,1'b1,2'b10,2'd3},
    {1'b0,1'b0,1'b0,2'b00,2'd0}
  };

  logic clk = 1'b0;
  logic rst_n, clr, issue_vld, sync, drafted;
  logic [1:0] dup_class;
  logic [ACC_W-1:0] energy_o;
  logic [CNT_W-1:0] cnt_full_o, cnt_part_o, cnt_ord_o;

  int total = 0;
  int bad = 0;
  longint unsigned e_acc = 0;
  longint unsigned e_full = 0, e_part = 0, e_ord = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edraft_energy_acc #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_dut (
    .clk, .rst_n, .clr, .issue_vld, .sync, .drafted, .dup_class,
    .energy_o, .cnt_full_o, .cnt_part_o, .cnt_ord_o
  );

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " energy"}, 64'(energy_o), e_acc);
    check({req, " full"}, 64'(cnt_full_o), e_full);
    check({req, " part"}, 64'(cnt_part_o), e_part);
    check({req, " ord"}, 64'(cnt_ord_o), e_ord);
  endtask

  task automatic charge(input int kind);
    longint unsigned c;
    c = (kind == 1) ? C_ORD : (kind == 2) ? C_PART : (kind == 3) ? C_FULL : 0;
    e_acc = (e_acc + c > MAXV) ? MAXV : e_acc + c;
    if (kind == 1) e_ord++;
    if (kind == 2) e_part++;
    if (kind == 3) e_full++;
  endtask

  // drive at a falling edge, result due after the next rising edge
  task automatic step(input logic iv, input logic sy, input logic dr, input logic [1:0] cl, input logic cr);
    issue_vld = iv; sync = sy; drafted = dr; dup_class = cl; clr = cr;
    @(negedge clk);
    issue_vld = 1'b0; clr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; issue_vld = 1'b0; sync = 1'b0; drafted = 1'b0; dup_class = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");

    // table walk: R2 ordinary, R3 full, R4 partial, R5 idle, R7 counters
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3:2], 1'b0);
      charge(int'(VEC[i][1:0]));
      check_all($sformatf("R2/R3/R4/R5/R7 vec%0d", i));
    end

    // R8: clear wins over a same-cycle issue
    step(1'b1, 1'b1, 1'b1, 2'b10, 1'b1);
    e_acc = 0; e_full = 0; e_part = 0; e_ord = 0;
    check_all("R8 clear with issue");

    step(1'b1, 1'b1, 1'b1, 2'b10, 1'b0);
    charge(3);
    check_all("R3 after clear");

    // R6: drive the total into saturation and keep issuing
    for (int i = 0; i < 40; i++) begin
      step(1'b1, 1'b0, 1'b0, 2'b00, 1'b0);
      charge(1);
    end
    check_all("R6 saturated");
    check("R6 at max", 64'(energy_o), MAXV);
    step(1'b1, 1'b0, 1'b1, 2'b01, 1'b0);
    charge(2);
    check_all("R6 hold");

    // R5: idle cycles leave everything unchanged
    step(1'b0, 1'b1, 1'b1, 2'b10, 1'b0);
    step(1'b0, 1'b0, 1'b1, 2'b01, 1'b0);
    check_all("R5 idle");

    // R1: reset in mid-run
    rst_n = 1'b0;
    #1;
    e_acc = 0; e_full = 0; e_part = 0; e_ord = 0;
    check_all("R1 mid reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 1'b1, 2'b01, 1'b0);
    charge(2);
    check_all("R4 after reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule